// File: doc/BRIEF.md
# Dual-Bank Sequencer Extended Register File

This block holds the extended mode-control registers of a display sequencer and serves them over a byte-wide index/data port pair. The host first writes an 8-bit index through the index port, then reads or writes the selected register through the data port. The block drives the stored control fields to the surrounding display logic.

Two control registers, mode control 1 and mode control 2, each have two copies: an old bank and a new bank. One bank is active at a time, and a data-port access to the version index selects it. A data write there activates the old bank. A data read there returns a fixed chip identifier and activates the new bank. The new-bank copy of mode control 1 stores its low nibble XOR-encoded and keeps its reserved bits at zero. The power-up mode register can only be written while the top bit of new-bank mode control 1 is set. The bank switch works only through separate byte strobes on the data port. Writing 0Bh to the index port alone switches nothing.

Top module: `seq_ext_regs`

## Requirements
- R1: The index register is 8 bits wide, holds its value until the index port is written again, and reads back on the index port. Index-port accesses have no side effect on any register or on the active bank.
- R2: A data-port write while the index is 0Bh activates the old bank (`new_bank_o` = 0). The written value is stored nowhere.
- R3: A data-port read while the index is 0Bh returns the CHIP_ID parameter (default 53h) and activates the new bank (`new_bank_o` = 1).
- R4: Indices 0Dh (mode control 2) and 0Eh (mode control 1) have separate old and new storage. Data-port reads and writes reach only the active bank, and the inactive copy keeps its value.
- R5: A new-bank write to index 0Eh stores bits 3:0 as the written nibble XOR 2h. A read returns the stored value with no XOR. Old-bank writes to 0Eh are stored unchanged.
- R6: Bits 6:4 of new-bank mode control 1 always read as zero. Bit 7 is stored as written.
- R7: A data-port write to index 0Ch updates the power-up mode register only while bit 7 of new-bank mode control 1 is set. Otherwise the write is dropped.
- R8: Data-port reads of any index other than 0Bh–0Eh return 00h, and writes to such an index change no register.
- R9: After reset the new bank is active, and the index and every control register are 00h.
- R10: Read data is registered. `rdata_o` takes the read value at the clock edge that samples `rd_i` and holds it until the next read. If `wr_i` and `rd_i` are both high, the write is performed and the read is dropped.
- R11: The power-up mode register and all four bank registers are driven continuously on their own output ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| sel_data_i | input | 1 | 0 selects the index port, 1 selects the data port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| new_bank_o | output | 1 | 1 when the new bank is active |
| pwr_mode_o | output | 8 | Power-up mode register (index 0Ch) |
| old_ctl1_o | output | 8 | Old-bank mode control 1 |
| old_ctl2_o | output | 8 | Old-bank mode control 2 |
| new_ctl1_o | output | 8 | New-bank mode control 1 (encoded as stored) |
| new_ctl2_o | output | 8 | New-bank mode control 2 |

## Verification
A wrong bank flag shows at the ports on the next data access to 0Dh or 0Eh. That access either returns the other copy or changes the inactive copy, and the exported register outputs show the latter one cycle after the write strobe. A wrong encoding or a lock that fails to hold shows on `new_ctl1_o` or `pwr_mode_o` at the edge after the write, and on `rdata_o` one cycle after the next read. Every scenario swaps banks both ways and reads both copies back, so a crossed write enable cannot stay hidden.

// File: rtl/seq_ext_regs_pkg.sv
package seq_ext_regs_pkg;
  localparam int unsigned IW = 8;
  localparam logic [IW-1:0] IDX_VER  = 8'h0B;
  localparam logic [IW-1:0] IDX_PWR  = 8'h0C;
  localparam logic [IW-1:0] IDX_CTL2 = 8'h0D;
  localparam logic [IW-1:0] IDX_CTL1 = 8'h0E;

  typedef enum logic {
    BANK_OLD = 1'b0,
    BANK_NEW = 1'b1
  } bank_e;
endpackage

// File: rtl/seq_ext_index.sv
module seq_ext_index #(
  parameter int unsigned IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] wdata_i,
  output logic [IW-1:0] index_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   index_o <= '0;
    else if (we_i) index_o <= wdata_i;
  end
endmodule

// File: rtl/seq_ext_bank.sv
module seq_ext_bank #(
  parameter int unsigned         DW       = 8,
  parameter bit                  ENCODE   = 1'b0,
  parameter logic [DW-1:0]       XOR_MASK = 8'h02,
  parameter logic [DW-1:0]       RESV_MSK = 8'h70
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_ctl1_i,
  input  logic          we_ctl2_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctl1_o,
  output logic [DW-1:0] ctl2_o
);
  logic [DW-1:0] ctl1_d;

  generate
    if (ENCODE) begin : g_enc
      // encode on write only; reserved bits are never stored
      assign ctl1_d = (wdata_i ^ XOR_MASK) & ~RESV_MSK;
    end else begin : g_raw
      assign ctl1_d = wdata_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl1_o <= '0;
      ctl2_o <= '0;
    end else begin
      if (we_ctl1_i) ctl1_o <= ctl1_d;
      if (we_ctl2_i) ctl2_o <= wdata_i;
    end
  end
endmodule

// File: rtl/seq_ext_rdmux.sv
module seq_ext_rdmux
  import seq_ext_regs_pkg::*;
#(
  parameter int unsigned   DW      = 8,
  parameter logic [DW-1:0] CHIP_ID = 8'h53
) (
  input  logic [IW-1:0] index_i,
  input  bank_e         bank_i,
  input  logic [DW-1:0] pwr_i,
  input  logic [DW-1:0] old_ctl1_i,
  input  logic [DW-1:0] old_ctl2_i,
  input  logic [DW-1:0] new_ctl1_i,
  input  logic [DW-1:0] new_ctl2_i,
  output logic [DW-1:0] data_o
);
  always_comb begin
    unique case (index_i)
      IDX_VER:  data_o = CHIP_ID;
      IDX_PWR:  data_o = pwr_i;
      IDX_CTL2: data_o = (bank_i == BANK_NEW) ? new_ctl2_i : old_ctl2_i;
      IDX_CTL1: data_o = (bank_i == BANK_NEW) ? new_ctl1_i : old_ctl1_i;
      default:  data_o = '0;
    endcase
  end
endmodule

// File: rtl/seq_ext_regs.sv
module seq_ext_regs
  import seq_ext_regs_pkg::*;
#(
  parameter int unsigned   DW       = 8,
  parameter logic [DW-1:0] CHIP_ID  = 8'h53,
  parameter logic [DW-1:0] XOR_MASK = 8'h02,
  parameter logic [DW-1:0] RESV_MSK = 8'h70
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          sel_data_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          new_bank_o,
  output logic [DW-1:0] pwr_mode_o,
  output logic [DW-1:0] old_ctl1_o,
  output logic [DW-1:0] old_ctl2_o,
  output logic [DW-1:0] new_ctl1_o,
  output logic [DW-1:0] new_ctl2_o
);
  localparam int unsigned LOCK_BIT = DW - 1;

  logic [IW-1:0] index_q;
  bank_e         bank_q;
  logic [DW-1:0] pwr_q;
  logic [DW-1:0] mux_data;
  logic          wr_idx, wr_dat, rd_any, rd_dat;
  logic          hit_ver, hit_pwr, hit_ctl1, hit_ctl2, act_new;
  logic [1:0]    we_ctl1, we_ctl2;   // [0]=old, [1]=new
  logic [DW-1:0] ctl1_q [2];
  logic [DW-1:0] ctl2_q [2];

  assign wr_idx = wr_i & ~sel_data_i;
  assign wr_dat = wr_i &  sel_data_i;
  assign rd_any = rd_i & ~wr_i;       // write wins on collision
  assign rd_dat = rd_any & sel_data_i;

  assign hit_ver  = (index_q == IDX_VER);
  assign hit_pwr  = (index_q == IDX_PWR);
  assign hit_ctl1 = (index_q == IDX_CTL1);
  assign hit_ctl2 = (index_q == IDX_CTL2);
  assign act_new  = (bank_q == BANK_NEW);

  assign we_ctl1 = {wr_dat & hit_ctl1 &  act_new, wr_dat & hit_ctl1 & ~act_new};
  assign we_ctl2 = {wr_dat & hit_ctl2 &  act_new, wr_dat & hit_ctl2 & ~act_new};

  seq_ext_index #(.IW(IW)) u_index (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_idx),
    .wdata_i (wdata_i[IW-1:0]),
    .index_o (index_q)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    seq_ext_bank #(
      .DW       (DW),
      .ENCODE   (b == 1),
      .XOR_MASK (XOR_MASK),
      .RESV_MSK (RESV_MSK)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_ctl1_i (we_ctl1[b]),
      .we_ctl2_i (we_ctl2[b]),
      .wdata_i   (wdata_i),
      .ctl1_o    (ctl1_q[b]),
      .ctl2_o    (ctl2_q[b])
    );
  end

  // version index access picks the active bank
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 bank_q <= BANK_NEW;
    else if (wr_dat && hit_ver)  bank_q <= BANK_OLD;
    else if (rd_dat && hit_ver)  bank_q <= BANK_NEW;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwr_q <= '0;
    else if (wr_dat && hit_pwr && ctl1_q[1][LOCK_BIT]) pwr_q <= wdata_i;
  end

  seq_ext_rdmux #(.DW(DW), .CHIP_ID(CHIP_ID)) u_rdmux (
    .index_i    (index_q),
    .bank_i     (bank_q),
    .pwr_i      (pwr_q),
    .old_ctl1_i (ctl1_q[0]),
    .old_ctl2_i (ctl2_q[0]),
    .new_ctl1_i (ctl1_q[1]),
    .new_ctl2_i (ctl2_q[1]),
    .data_o     (mux_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= '0;
    else if (rd_any) rdata_o <= sel_data_i ? mux_data : DW'(index_q);
  end

  assign new_bank_o = act_new;
  assign pwr_mode_o = pwr_q;
  assign old_ctl1_o = ctl1_q[0];
  assign old_ctl2_o = ctl2_q[0];
  assign new_ctl1_o = ctl1_q[1];
  assign new_ctl2_o = ctl2_q[1];

  // R2
  a_r2_wr_ver_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_data_i && index_q == IDX_VER) |=> !new_bank_o);
  // R3
  a_r3_rd_ver_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && sel_data_i && index_q == IDX_VER) |=> (new_bank_o && rdata_o == CHIP_ID));
  // R4
  a_r4_old_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_bank_o) |=> ($stable(old_ctl1_o) && $stable(old_ctl2_o)));
  a_r4_new_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!new_bank_o) |=> ($stable(new_ctl1_o) && $stable(new_ctl2_o)));
  // R5
  a_r5_xor_nibble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_data_i && index_q == IDX_CTL1 && new_bank_o)
      |=> (new_ctl1_o[3:0] == ($past(wdata_i[3:0]) ^ XOR_MASK[3:0])));
  // R6
  a_r6_resv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_ctl1_o & RESV_MSK) == '0);
  // R7
  a_r7_pwr_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!new_ctl1_o[LOCK_BIT]) |=> $stable(pwr_mode_o));
  // R1
  a_r1_idx_no_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_i || rd_i) || !sel_data_i) |=> $stable(new_bank_o));
endmodule

// File: tb/sim_seq_ext_regs.sv
module sim_seq_ext_regs;
  localparam logic [7:0] CHIP = 8'h53;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0, sel = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rdata, pwr, oc1, oc2, nc1, nc2;
  logic       nbank;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  seq_ext_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .sel_data_i(sel),
    .wdata_i(wd), .rdata_o(rdata), .new_bank_o(nbank), .pwr_mode_o(pwr),
    .old_ctl1_o(oc1), .old_ctl2_o(oc2), .new_ctl1_o(nc1), .new_ctl2_o(nc2)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_port(logic s, logic [7:0] d);
    @(negedge clk); wr = 1'b1; sel = s; wd = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_port(logic s, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; sel = s;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic wreg(logic [7:0] idx, logic [7:0] d);
    wr_port(1'b0, idx); wr_port(1'b1, d);
  endtask

  task automatic rreg(logic [7:0] idx, output logic [7:0] d);
    wr_port(1'b0, idx); rd_port(1'b1, d);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R9 new bank", {7'd0, nbank}, 8'h01);
    chk("R9 pwr", pwr, 8'h00);
    chk("R9 oc1", oc1, 8'h00);
    chk("R9 nc2", nc2, 8'h00);
    rd_port(1'b0, v);
    chk("R9 index", v, 8'h00);
  endtask

  task automatic t_index;
    logic [7:0] v;
    wr_port(1'b0, 8'h0B);
    chk("R1 idx write no switch", {7'd0, nbank}, 8'h01);
    rd_port(1'b0, v);
    chk("R1 idx readback", v, 8'h0B);
    chk("R1 idx read no switch", {7'd0, nbank}, 8'h01);
    rd_port(1'b0, v);
    chk("R1 idx held", v, 8'h0B);
  endtask

  task automatic t_banks;
    logic [7:0] v;
    wreg(8'h0B, 8'hFF);
    chk("R2 old active", {7'd0, nbank}, 8'h00);
    wreg(8'h0D, 8'h5A);
    wreg(8'h0E, 8'h07);
    chk("R4 old ctl2 out", oc2, 8'h5A);
    chk("R11 new ctl2 untouched", nc2, 8'h00);
    rreg(8'h0E, v);
    chk("R5 old ctl1 unencoded", v, 8'h07);
    rreg(8'h0B, v);
    chk("R3 chip id", v, CHIP);
    chk("R3 new active", {7'd0, nbank}, 8'h01);
    rreg(8'h0D, v);
    chk("R4 new ctl2 read", v, 8'h00);
    wreg(8'h0D, 8'hA5);
    chk("R4 old ctl2 kept", oc2, 8'h5A);
    wreg(8'h0B, 8'h00);
    rreg(8'h0D, v);
    chk("R4 old ctl2 read", v, 8'h5A);
    rreg(8'h0B, v);
    rreg(8'h0D, v);
    chk("R4 new ctl2 read", v, 8'hA5);
  endtask

  task automatic t_encode;
    logic [7:0] v;
    wreg(8'h0E, 8'h07);
    rreg(8'h0E, v);
    chk("R5 xor on write", v, 8'h05);
    wreg(8'h0E, 8'h7F);
    rreg(8'h0E, v);
    chk("R6 reserved zero", v, 8'h0D);
    chk("R11 nc1 out", nc1, 8'h0D);
    chk("R4 old ctl1 kept", oc1, 8'h07);
  endtask

  task automatic t_lock;
    logic [7:0] v;
    wreg(8'h0C, 8'hAB);
    chk("R7 locked out", pwr, 8'h00);
    rreg(8'h0C, v);
    chk("R7 locked read", v, 8'h00);
    wreg(8'h0E, 8'h80);
    chk("R6 bit7 kept", nc1, 8'h82);
    wreg(8'h0C, 8'hAB);
    rreg(8'h0C, v);
    chk("R7 unlocked", v, 8'hAB);
    chk("R11 pwr out", pwr, 8'hAB);
  endtask

  task automatic t_unimpl;
    logic [7:0] v;
    wreg(8'h30, 8'hC3);
    rreg(8'h30, v);
    chk("R8 unimpl read", v, 8'h00);
    chk("R8 pwr unchanged", pwr, 8'hAB);
    chk("R8 nc2 unchanged", nc2, 8'hA5);
    rreg(8'h0A, v);
    chk("R8 below range", v, 8'h00);
  endtask

  task automatic t_timing;
    logic [7:0] v;
    wr_port(1'b0, 8'h0C);
    @(negedge clk); rd = 1'b1; sel = 1'b1;
    @(posedge clk); #1;
    chk("R10 data after edge", rdata, 8'hAB);
    @(negedge clk); rd = 1'b0;
    wr_port(1'b0, 8'h0D);
    repeat (3) @(negedge clk);
    chk("R10 data held", rdata, 8'hAB);
    wr_port(1'b0, 8'h0B);
    @(negedge clk); rd = 1'b1; wr = 1'b1; sel = 1'b1; wd = 8'h00;
    @(negedge clk); rd = 1'b0; wr = 1'b0;
    chk("R10 collision write wins", {7'd0, nbank}, 8'h00);
    chk("R10 collision no read", rdata, 8'hAB);
    rd_port(1'b1, v);
    chk("R10 plain read", v, CHIP);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_index();
    t_banks();
    t_encode();
    t_lock();
    t_unimpl();
    t_timing();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule